// File: doc/BRIEF.md
# PHY Delay Register Access Port

This block lets host software reach a small bank of byte-wide PHY delay settings through a single 32-bit host register. Software writes one word that holds a PHY address, a write byte and two request flags. The block then runs the access on an internal PHY-side strobe bus and raises an acknowledge flag in the same word. For a read, the byte fetched from the PHY appears in a read-data field of that word.

Each access follows a four-phase handshake. Software first loads the address and data with both request flags clear. It then sets one request flag and polls until acknowledge is set. Finally it clears the request, and acknowledge returns to zero. The PHY bank has a fixed access latency, so the whole access finishes within a few clock cycles. That is far inside the roughly 10 us a host waits before it gives up.

The bank implements twelve delay slots. Slots 0x00 to 0x08 hold the input delays for the card speed modes. Slots 0x0B, 0x0C and 0x0D hold the DLL clock delay, the high-speed MMC clock delay and the strobe delay. Every other address is unimplemented.

Top module: `phy_access_port`

## Requirements
- R1: The host word reads back as follows. Bits 7:0 hold the address and bits 15:8 the write byte, both as last written. Bits 23:16 hold the read-data field. Bit 24 is the write request and bit 25 the read request, both as last written. Bit 26 is acknowledge. Bits 31:27 read as zero. Host writes to bits 23:16, 26 and 31:27 have no effect.
- R2: Acknowledge (bit 26) rises exactly LAT+2 clock edges after the host write that sets a request flag. LAT is the PHY bank latency parameter, and its default is 2.
- R3: Acknowledge stays at 1 for as long as at least one request flag is set.
- R4: Acknowledge returns to 0 on the first clock edge after the host write that clears both request flags.
- R5: The implemented addresses are 0x00–0x08 and 0x0B–0x0D. A write stores the byte at the address. A later read returns that byte in bits 23:16.
- R6: At any other address a write changes nothing, and a read returns 0x00.
- R7: If both request flags are set together, the access is a write, and the read-data field keeps its previous value.
- R8: The read-data field changes only on the edge where acknowledge rises for a read access. It holds its value at all other times.
- R9: While acknowledge is 1, no new PHY access starts. Changes to the address, the data or the request flags have no effect on the bank until acknowledge has dropped.
- R10: After reset, all delay slots and all fields of the host word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe for the access word |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Current value of the access word |

## Verification
The bench writes a distinct byte to every one of the 256 addresses and then reads each one back. A decoder that let an unimplemented address alias onto a slot would return a nonzero byte where zero is expected. A decoder that dropped an implemented slot would return zero in its place. The latency from a request to acknowledge is counted edge by edge, so a lost or extra pipeline stage shows up as a wrong count. Other corner cases are covered:
- A request held across acknowledge while its address and data are changed; a design that re-issued the access would overwrite a slot.
- Both request flags set at once; a design that preferred the read, or updated the read field on a write, would corrupt the field.
- The exact cycle in which acknowledge drops after release.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
  localparam int FIELD_W   = 8;
  localparam int ADDR_LSB  = 0;
  localparam int WDATA_LSB = 8;
  localparam int RDATA_LSB = 16;
  localparam int WR_BIT    = 24;
  localparam int RD_BIT    = 25;
  localparam int ACK_BIT   = 26;
  localparam int WORD_W    = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ACK  = 2'd2
  } acc_state_e;

  typedef struct packed {
    logic               we;
    logic [FIELD_W-1:0] addr;
    logic [FIELD_W-1:0] data;
  } phy_cmd_t;
endpackage

// File: rtl/phy_port_hreg.sv
module phy_port_hreg
  import phy_port_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [FIELD_W-1:0] addr_o,
  output logic [FIELD_W-1:0] wbyte_o,
  output logic               wr_req_o,
  output logic               rd_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      wbyte_o  <= '0;
      wr_req_o <= 1'b0;
      rd_req_o <= 1'b0;
    end else if (we_i) begin
      addr_o   <= wdata_i[ADDR_LSB +: FIELD_W];
      wbyte_o  <= wdata_i[WDATA_LSB +: FIELD_W];
      wr_req_o <= wdata_i[WR_BIT];
      rd_req_o <= wdata_i[RD_BIT];
    end
  end
endmodule

// File: rtl/phy_port_ctrl.sv
module phy_port_ctrl
  import phy_port_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_req_i,
  input  logic               rd_req_i,
  input  logic [FIELD_W-1:0] addr_i,
  input  logic [FIELD_W-1:0] wbyte_i,
  input  logic               phy_done_i,
  input  logic [FIELD_W-1:0] phy_rdata_i,
  output logic               phy_strobe_o,
  output phy_cmd_t           phy_cmd_o,
  output logic               ack_o,
  output logic [FIELD_W-1:0] rfield_o
);
  acc_state_e state_q;
  logic       req_any;

  assign req_any = wr_req_i | rd_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      phy_strobe_o <= 1'b0;
      phy_cmd_o    <= '0;
      ack_o        <= 1'b0;
      rfield_o     <= '0;
    end else begin
      phy_strobe_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_any) begin
            // write wins when both flags are set
            phy_cmd_o    <= '{we: wr_req_i, addr: addr_i, data: wbyte_i};
            phy_strobe_o <= 1'b1;
            state_q      <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (phy_done_i) begin
            ack_o   <= 1'b1;
            state_q <= ST_ACK;
            if (!phy_cmd_o.we) rfield_o <= phy_rdata_i;
          end
        end
        ST_ACK: begin
          if (!req_any) begin
            ack_o   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_delay_bank.sv
module phy_delay_bank
  import phy_port_pkg::*;
#(
  parameter int          LAT       = 2,
  parameter int          SLOTS     = 16,
  parameter logic [15:0] IMPL_MASK = 16'h39FF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  phy_cmd_t           cmd_i,
  output logic               done_o,
  output logic [FIELD_W-1:0] rdata_o
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [FIELD_W-1:0] slot_q [SLOTS];
  logic               in_range;
  logic [IDX_W-1:0]   idx;
  logic [FIELD_W-1:0] rd_byte;

  assign in_range = (cmd_i.addr >> IDX_W) == '0;
  assign idx      = cmd_i.addr[IDX_W-1:0];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (IMPL_MASK[g]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          slot_q[g] <= '0;
        else if (strobe_i && cmd_i.we && in_range && idx == IDX_W'(g))
          slot_q[g] <= cmd_i.data;
      end
    end else begin : g_hole
      assign slot_q[g] = '0;
    end
  end

  assign rd_byte = in_range ? slot_q[idx] : '0;

  logic [LAT-1:0]     vld_q;
  logic [FIELD_W-1:0] pipe_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q[0]  <= 1'b0;
      pipe_q[0] <= '0;
    end else begin
      vld_q[0]  <= strobe_i;
      pipe_q[0] <= rd_byte;
    end
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s]  <= 1'b0;
        pipe_q[s] <= '0;
      end else begin
        vld_q[s]  <= vld_q[s-1];
        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign done_o  = vld_q[LAT-1];
  assign rdata_o = pipe_q[LAT-1];
endmodule

// File: rtl/phy_access_port.sv
module phy_access_port
  import phy_port_pkg::*;
#(
  parameter int          LAT       = 2,
  parameter int          SLOTS     = 16,
  parameter logic [15:0] IMPL_MASK = 16'h39FF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_we_i,
  input  logic [31:0] host_wdata_i,
  output logic [31:0] host_rdata_o
);
  logic [FIELD_W-1:0] addr, wbyte, rfield, phy_rdata;
  logic               wr_req, rd_req, req_any, ack, phy_strobe, phy_done;
  phy_cmd_t           phy_cmd;

  phy_port_hreg u_hreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (host_we_i),
    .wdata_i  (host_wdata_i),
    .addr_o   (addr),
    .wbyte_o  (wbyte),
    .wr_req_o (wr_req),
    .rd_req_o (rd_req)
  );

  phy_port_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_req_i     (wr_req),
    .rd_req_i     (rd_req),
    .addr_i       (addr),
    .wbyte_i      (wbyte),
    .phy_done_i   (phy_done),
    .phy_rdata_i  (phy_rdata),
    .phy_strobe_o (phy_strobe),
    .phy_cmd_o    (phy_cmd),
    .ack_o        (ack),
    .rfield_o     (rfield)
  );

  phy_delay_bank #(
    .LAT       (LAT),
    .SLOTS     (SLOTS),
    .IMPL_MASK (IMPL_MASK)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (phy_strobe),
    .cmd_i    (phy_cmd),
    .done_o   (phy_done),
    .rdata_o  (phy_rdata)
  );

  assign req_any = wr_req | rd_req;

  always_comb begin
    host_rdata_o                         = '0;
    host_rdata_o[ADDR_LSB +: FIELD_W]    = addr;
    host_rdata_o[WDATA_LSB +: FIELD_W]   = wbyte;
    host_rdata_o[RDATA_LSB +: FIELD_W]   = rfield;
    host_rdata_o[WR_BIT]                 = wr_req;
    host_rdata_o[RD_BIT]                 = rd_req;
    host_rdata_o[ACK_BIT]                = ack;
  end
endmodule

// File: rtl/phy_access_port_chk.sv
module phy_access_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_i,
  input logic       req_i,
  input logic       strobe_i,
  input logic       done_i,
  input logic [7:0] rfield_i
);
  assert_ack_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && req_i |=> ack_i);

  assert_ack_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !req_i |=> !ack_i);

  assert_no_issue_during_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({strobe_i, done_i, ack_i}));

  assert_rfield_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rfield_i) |-> $rose(ack_i));

  assert_ack_after_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_i) |-> $past(done_i));
endmodule

bind phy_access_port phy_access_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_i    (ack),
  .req_i    (req_any),
  .strobe_i (phy_strobe),
  .done_i   (phy_done),
  .rfield_i (rfield)
);

// File: tb/phy_access_port_bench.sv
`timescale 1ns/1ps
module phy_access_port_bench;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  int          checks = 0;
  int          fails = 0;
  logic [7:0]  rfield_exp = 8'h00;

  always #10 clk = ~clk;

  phy_access_port #(.LAT(LAT)) u_phy_access_port (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .host_we_i    (we),
    .host_wdata_i (wd),
    .host_rdata_o (rd)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  function automatic bit impl(int a);
    return (a <= 8) || (a >= 11 && a <= 13);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(logic [31:0] w);
    @(negedge clk);
    we = 1'b1;
    wd = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [31:0] word(bit wr, bit rq, logic [7:0] d, logic [7:0] a);
    return {6'b0, rq, wr, 8'h00, d, a};
  endfunction

  // full four-phase access; returns edges to ack
  task automatic access(bit wr, bit rq, logic [7:0] a, logic [7:0] d, output int lat);
    host_wr(word(1'b0, 1'b0, d, a));
    host_wr(word(wr, rq, d, a));
    lat = 0;
    while (!rd[26] && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    host_wr(word(1'b0, 1'b0, d, a));
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(rd == 32'h0, "R10 host word", rd, 32'h0);
    for (int a = 0; a < 16; a++) begin
      access(1'b0, 1'b1, 8'(a), 8'h00, lat);
      chk(rd[23:16] == 8'h00, "R10 slot", rd[23:16], 8'h00);
    end

    // R2 latency and R3/R4 handshake on one write
    host_wr(word(1'b0, 1'b0, 8'h11, 8'h00));
    host_wr(word(1'b1, 1'b0, 8'h11, 8'h00));
    lat = 0;
    while (!rd[26] && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == LAT + 2, "R2 ack latency", lat, LAT + 2);
    repeat (6) @(negedge clk);
    chk(rd[26] == 1'b1, "R3 ack held", rd[26], 1);
    host_wr(word(1'b0, 1'b0, 8'h11, 8'h00));
    chk(rd[26] == 1'b1, "R4 ack before drop edge", rd[26], 1);
    @(negedge clk);
    chk(rd[26] == 1'b0, "R4 ack dropped", rd[26], 0);

    // R5/R6 sweep: write every address, then read every address
    for (int a = 0; a < 256; a++) begin
      access(1'b1, 1'b0, 8'(a), pat(a), lat);
      if (a == 200) chk(lat == LAT + 2, "R2 write latency", lat, LAT + 2);
    end
    for (int a = 0; a < 256; a++) begin
      logic [7:0] e;
      e = impl(a) ? pat(a) : 8'h00;
      access(1'b0, 1'b1, 8'(a), 8'h00, lat);
      if (impl(a)) chk(rd[23:16] == e, "R5 slot readback", rd[23:16], e);
      else         chk(rd[23:16] == e, "R6 hole reads zero", rd[23:16], e);
      if (a == 7) chk(lat == LAT + 2, "R2 read latency", lat, LAT + 2);
    end

    // R8: a write leaves the read field alone
    access(1'b0, 1'b1, 8'h05, 8'h00, lat);
    rfield_exp = pat(5);
    access(1'b1, 1'b0, 8'h06, 8'hC3, lat);
    chk(rd[23:16] == rfield_exp, "R8 field held over write", rd[23:16], rfield_exp);

    // R7: both flags set -> write, field unchanged
    access(1'b1, 1'b1, 8'h03, 8'h5A, lat);
    chk(rd[23:16] == rfield_exp, "R7 field kept", rd[23:16], rfield_exp);
    access(1'b0, 1'b1, 8'h03, 8'h00, lat);
    chk(rd[23:16] == 8'h5A, "R7 write performed", rd[23:16], 8'h5A);

    // R9: changes while ack is high start nothing
    host_wr(word(1'b0, 1'b0, 8'h77, 8'h0B));
    host_wr(word(1'b1, 1'b0, 8'h77, 8'h0B));
    repeat (LAT + 4) @(negedge clk);
    host_wr(word(1'b1, 1'b0, 8'hEE, 8'h04));
    repeat (8) @(negedge clk);
    chk(rd[26] == 1'b1, "R3 ack held over new word", rd[26], 1);
    host_wr(word(1'b0, 1'b0, 8'hEE, 8'h04));
    @(negedge clk);
    access(1'b0, 1'b1, 8'h04, 8'h00, lat);
    chk(rd[23:16] == pat(4), "R9 slot not rewritten", rd[23:16], pat(4));
    access(1'b0, 1'b1, 8'h0B, 8'h00, lat);
    chk(rd[23:16] == 8'h77, "R9 first write done", rd[23:16], 8'h77);
    rfield_exp = 8'h77;

    // R1: field layout and read-only bits
    host_wr(32'hFCAB_3412);
    chk(rd == {8'h00, rfield_exp, 16'h3412}, "R1 word layout", rd, {8'h00, rfield_exp, 16'h3412});
    host_wr(32'h0000_2199);
    chk(rd == {8'h00, rfield_exp, 16'h2199}, "R1 readback", rd, {8'h00, rfield_exp, 16'h2199});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule